// File: doc/BRIEF.md
# Thread Block Dispatcher

This block takes a kernel launch described by a problem size `n` and splits it into thread blocks of a fixed size. The block count is the ceiling of `n / BLK_DIM`. Blocks go out in rising index order, one per cycle at most, to a set of multiprocessor slots. Each slot holds one resident block and stays busy until it reports completion.

For each dispatched block the dispatcher presents several values:
- the block index;
- the global index of the block's first thread (`blockIdx * BLK_DIM`);
- a per-thread active mask that clears every thread whose global index is `n` or above;
- a per-warp mask that marks warps with at least one active thread.

A lane lookup port returns the global index of any thread in the block being dispatched. A one-cycle done pulse ends the launch once every block has retired.

Top module: `tblk_dispatcher`

## Requirements
- R1: `launch_rdy` is 1 while no launch is running. A launch is accepted on a clock edge where `launch_vld` and `launch_rdy` are both 1. After an accepted launch with `n > 0`, `launch_rdy` is 0 from the next cycle until the cycle in which `done` is 1.
- R2: An accepted launch dispatches exactly ceil(`n` / `BLK_DIM`) blocks.
- R3: Block indices are dispatched as 0, 1, 2, … in increasing order, with at most one dispatch per cycle.
- R4: `disp_vld` is one-hot or zero. Bit `s` set means the block goes to slot `s`. The slot chosen is the lowest-numbered slot that is not holding a block.
- R5: A slot holds its block until a cycle in which its bit of `slot_cmpl` is 1. It is free from the following cycle. A `slot_cmpl` bit for a slot that holds no block has no effect.
- R6: During a dispatch, `disp_base` equals `disp_blk * BLK_DIM` and `lane_gidx` equals `disp_base + lane_sel`.
- R7: During a dispatch, bit `t` of `disp_tmask` is 1 exactly when `disp_base + t < n`. Bit `w` of `disp_wmask` is 1 exactly when any of thread bits `WARP*w` to `WARP*w+WARP-1` is 1.
- R8: `done` is 1 for one cycle. That cycle is the one after the clock edge at which the last outstanding block's completion is taken, and `launch_rdy` returns to 1 in the same cycle.
- R9: A launch with `n = 0` dispatches nothing and raises `done` in the cycle after acceptance.
- R10: `launch_vld` and `launch_n` have no effect while a launch is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_vld | input | 1 | Launch request |
| launch_n | input | NW | Problem size in threads |
| launch_rdy | output | 1 | Dispatcher idle, launch can be taken |
| slot_cmpl | input | NUM_SLOTS | Per-slot block completion |
| disp_vld | output | NUM_SLOTS | One-hot dispatch to a slot |
| disp_blk | output | NW+1 | Index of the dispatched block |
| disp_base | output | NW+1 | Global index of the block's thread 0 |
| disp_tmask | output | BLK_DIM | Per-thread active mask |
| disp_wmask | output | BLK_DIM/WARP | Per-warp active mask |
| lane_sel | input | log2(BLK_DIM) | Thread index to look up |
| lane_gidx | output | NW+1 | Global index of the selected thread |
| done | output | 1 | One-cycle pulse when all blocks have retired |

## Verification
A dispatch into one free slot and completions from other slots can fall in the same cycle. The dispatch uses the occupancy left by the previous edge, while the retirement count must take in every completion at once. The bench keeps completions continuously staggered: each dispatched block gets a short hold time computed from its index and slot. It also adds a completion on a rotating slot that is idle, so dispatch, several retirements and ignored completions coincide often. The reference model is compared every cycle on slot choice, block index, masks, ready and done timing, and the dispatch count is checked when each launch ends.

// File: rtl/tbd_pkg.sv
// Shared types for the thread block dispatcher.
// Assumes nothing beyond a two-state controller.
package tbd_pkg;
    typedef enum logic {
        TD_IDLE = 1'b0,
        TD_RUN  = 1'b1
    } tbd_state_e;
endpackage

// File: rtl/tbd_slot_pick.sv
// Lowest-index free slot picker.
// Takes a free vector and returns a one-hot grant of its lowest set bit.
// Assumes NUM_SLOTS >= 1.
module tbd_slot_pick #(
    parameter int NUM_SLOTS = 16
) (
    input  logic [NUM_SLOTS-1:0] free_vec,
    output logic [NUM_SLOTS-1:0] grant,
    output logic                 any_free
);
    // Priority scan from slot 0 upward.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (free_vec[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        any_free = taken;
    end
endmodule

// File: rtl/tbd_thread_mask.sv
// Per-thread and per-warp active masks for one block.
// A thread is active while base + t < n. Assumes BLK_DIM is a multiple of WARP
// and that base + BLK_DIM fits in IW bits.
module tbd_thread_mask #(
    parameter int BLK_DIM = 512,
    parameter int WARP    = 32,
    parameter int IW      = 17
) (
    input  logic [IW-1:0]           base,
    input  logic [IW-1:0]           n_lim,
    output logic [BLK_DIM-1:0]      tmask,
    output logic [BLK_DIM/WARP-1:0] wmask
);
    localparam int NWARP = BLK_DIM / WARP;

    for (genvar t = 0; t < BLK_DIM; t++) begin : g_thr
        localparam logic [IW-1:0] OFS = IW'(t);
        // One guard comparator per thread lane.
        assign tmask[t] = (base + OFS) < n_lim;
    end

    for (genvar w = 0; w < NWARP; w++) begin : g_warp
        // A warp is live when any of its lanes is live.
        assign wmask[w] = |tmask[w*WARP +: WARP];
    end
endmodule

// File: rtl/tbd_launch_ctl.sv
// Launch controller: accepts a launch, counts blocks out and back in,
// tracks slot occupancy and raises a one-cycle done pulse.
// Assumes grant is the one-hot pick among ~occ produced outside.
module tbd_launch_ctl
    import tbd_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int BLK_DIM   = 512,
    parameter int NW        = 16,
    parameter int IW        = NW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_vld,
    input  logic [NW-1:0]        launch_n,
    output logic                 launch_rdy,
    input  logic [NUM_SLOTS-1:0] slot_cmpl,
    input  logic [NUM_SLOTS-1:0] grant,
    input  logic                 any_free,
    output logic [NUM_SLOTS-1:0] occ,
    output logic                 disp_fire,
    output logic [IW-1:0]        blk_q,
    output logic [IW-1:0]        base_q,
    output logic [IW-1:0]        n_q,
    output logic                 done
);
    localparam logic [IW-1:0] BLK_W = IW'(BLK_DIM);
    localparam int            CW    = $clog2(NUM_SLOTS + 1);

    tbd_state_e           state;
    logic [IW-1:0]        total_q;
    logic [IW-1:0]        ret_cnt_q;
    logic [IW-1:0]        nblk;
    logic [NUM_SLOTS-1:0] ret_vec;
    logic [CW-1:0]        ret_num;
    logic [IW-1:0]        ret_next;

    // Ceiling division of the requested size by the block size.
    assign nblk = ({1'b0, launch_n} + BLK_W - IW'(1)) / BLK_W;

    assign launch_rdy = (state == TD_IDLE);
    assign disp_fire  = (state == TD_RUN) && (blk_q < total_q) && any_free;

    // Completions count only for slots that hold a block.
    always_comb begin
        ret_vec = occ & slot_cmpl;
        ret_num = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            ret_num = ret_num + CW'(ret_vec[i]);
        end
        ret_next = ret_cnt_q + IW'(ret_num);
    end

    // Controller state, counters and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TD_IDLE;
            total_q   <= '0;
            ret_cnt_q <= '0;
            blk_q     <= '0;
            base_q    <= '0;
            n_q       <= '0;
            occ       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == TD_IDLE) begin
                if (launch_vld) begin
                    n_q       <= {1'b0, launch_n};
                    total_q   <= nblk;
                    blk_q     <= '0;
                    base_q    <= '0;
                    ret_cnt_q <= '0;
                    if (nblk == '0) done  <= 1'b1;
                    else            state <= TD_RUN;
                end
            end else begin
                occ       <= (occ & ~ret_vec) | (disp_fire ? grant : '0);
                ret_cnt_q <= ret_next;
                if (disp_fire) begin
                    blk_q  <= blk_q + IW'(1);
                    base_q <= base_q + BLK_W;
                end
                if (ret_next == total_q) begin
                    state <= TD_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tblk_dispatcher.sv
// Thread block dispatcher top: splits a launch of n threads into blocks of
// BLK_DIM, hands them to NUM_SLOTS slots (one resident block each) and emits
// per-block thread/warp masks plus a lane index lookup.
// Assumes BLK_DIM is a multiple of WARP and no larger than 2**NW.
module tblk_dispatcher #(
    parameter int NUM_SLOTS = 16,
    parameter int BLK_DIM   = 512,
    parameter int WARP      = 32,
    parameter int NW        = 16,
    parameter int IW        = NW + 1,
    parameter int LW        = $clog2(BLK_DIM),
    parameter int NWARP     = BLK_DIM / WARP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch_vld,
    input  logic [NW-1:0]        launch_n,
    output logic                 launch_rdy,
    input  logic [NUM_SLOTS-1:0] slot_cmpl,
    output logic [NUM_SLOTS-1:0] disp_vld,
    output logic [IW-1:0]        disp_blk,
    output logic [IW-1:0]        disp_base,
    output logic [BLK_DIM-1:0]   disp_tmask,
    output logic [NWARP-1:0]     disp_wmask,
    input  logic [LW-1:0]        lane_sel,
    output logic [IW-1:0]        lane_gidx,
    output logic                 done
);
    logic [NUM_SLOTS-1:0] occ;
    logic [NUM_SLOTS-1:0] grant;
    logic                 any_free;
    logic                 disp_fire;
    logic [IW-1:0]        n_q;

    tbd_slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .free_vec (~occ),
        .grant    (grant),
        .any_free (any_free)
    );

    tbd_launch_ctl #(
        .NUM_SLOTS(NUM_SLOTS), .BLK_DIM(BLK_DIM), .NW(NW), .IW(IW)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_vld (launch_vld),
        .launch_n   (launch_n),
        .launch_rdy (launch_rdy),
        .slot_cmpl  (slot_cmpl),
        .grant      (grant),
        .any_free   (any_free),
        .occ        (occ),
        .disp_fire  (disp_fire),
        .blk_q      (disp_blk),
        .base_q     (disp_base),
        .n_q        (n_q),
        .done       (done)
    );

    tbd_thread_mask #(.BLK_DIM(BLK_DIM), .WARP(WARP), .IW(IW)) u_mask (
        .base  (disp_base),
        .n_lim (n_q),
        .tmask (disp_tmask),
        .wmask (disp_wmask)
    );

    assign disp_vld  = disp_fire ? grant : '0;
    assign lane_gidx = disp_base + IW'(lane_sel);
endmodule

// File: rtl/tblk_dispatcher_chk.sv
// Port-level checker for the dispatcher, bound to every instance.
// Keeps its own view of slot occupancy and of the expected next block index.
module tblk_dispatcher_chk #(
    parameter int NUM_SLOTS = 16,
    parameter int BLK_DIM   = 512,
    parameter int IW        = 17
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 launch_vld,
    input logic                 launch_rdy,
    input logic [NUM_SLOTS-1:0] slot_cmpl,
    input logic [NUM_SLOTS-1:0] disp_vld,
    input logic [IW-1:0]        disp_blk,
    input logic [IW-1:0]        disp_base,
    input logic [BLK_DIM-1:0]   disp_tmask
);
    logic [NUM_SLOTS-1:0] held;
    logic [IW-1:0]        next_blk;

    // Shadow occupancy and block counter rebuilt from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= '0;
            next_blk <= '0;
        end else begin
            held <= (held & ~slot_cmpl) | disp_vld;
            if (launch_vld && launch_rdy) next_blk <= '0;
            else if (disp_vld != '0)      next_blk <= next_blk + IW'(1);
        end
    end

    AST_DISP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_vld)); // R4
    AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld & held) == '0); // R5
    AST_BLK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld != '0) |-> (disp_blk == next_blk)); // R3
    AST_IDLE_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        launch_rdy |-> (disp_vld == '0)); // R1
    AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld != '0) |-> (disp_base == disp_blk * IW'(BLK_DIM))); // R6
    AST_LEAD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_vld != '0) |-> disp_tmask[0]); // R7
endmodule

bind tblk_dispatcher tblk_dispatcher_chk #(
    .NUM_SLOTS(NUM_SLOTS), .BLK_DIM(BLK_DIM), .IW(IW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_vld (launch_vld),
    .launch_rdy (launch_rdy),
    .slot_cmpl  (slot_cmpl),
    .disp_vld   (disp_vld),
    .disp_blk   (disp_blk),
    .disp_base  (disp_base),
    .disp_tmask (disp_tmask)
);

// File: tb/sim_tblk_dispatcher.sv
// Bench: behavioural reference model compared on every cycle.
module sim_tblk_dispatcher;
    localparam int NS = 16, BD = 512, WP = 32, NW = 16, IW = 17, LW = 9, NWP = 16;
    localparam int NL = 10;
    localparam int LIM = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_vld = 1'b0;
    logic [NW-1:0] launch_n = '0;
    logic launch_rdy;
    logic [NS-1:0] slot_cmpl = '0;
    logic [NS-1:0] disp_vld;
    logic [IW-1:0] disp_blk, disp_base, lane_gidx;
    logic [BD-1:0] disp_tmask;
    logic [NWP-1:0] disp_wmask;
    logic [LW-1:0] lane_sel = '0;
    logic done;

    always #2.5 clk = ~clk;

    tblk_dispatcher u0 (
        .clk(clk), .rst_n(rst_n), .launch_vld(launch_vld), .launch_n(launch_n),
        .launch_rdy(launch_rdy), .slot_cmpl(slot_cmpl), .disp_vld(disp_vld),
        .disp_blk(disp_blk), .disp_base(disp_base), .disp_tmask(disp_tmask),
        .disp_wmask(disp_wmask), .lane_sel(lane_sel), .lane_gidx(lane_gidx),
        .done(done)
    );

    int checks = 0, fails = 0;
    int sizes[NL] = '{0, 1, 512, 513, 8192, 20000, 0, 0, 1000, 7};

    // model state
    int m_busy, m_n, m_total, m_nxt, m_dcnt, m_disp;
    bit m_occ[NS];
    bit m_done;
    int hold[NS];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        int li, cyc, slot, nd;
        logic [NS-1:0] cm, ev;
        logic [BD-1:0] et;
        logic [NWP-1:0] ew;
        li = 0; cyc = 0;
        m_busy = 0; m_n = 0; m_total = 0; m_nxt = 0; m_dcnt = 0; m_disp = 0; m_done = 0;
        for (int i = 0; i < NS; i++) begin m_occ[i] = 0; hold[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R1, R8)
        chk(launch_rdy == 1'b1, "R1 reset ready", launch_rdy, 1);
        chk(done == 1'b0, "R8 reset done", done, 0);
        chk(disp_vld == '0, "R4 reset dispatch", disp_vld, 0);
        while (li < NL || m_busy != 0 || m_done) begin
            cyc++;
            if (cyc > LIM) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIM);
                break;
            end
            // expected outputs from model state
            slot = -1;
            if (m_busy != 0 && m_nxt < m_total)
                for (int i = NS - 1; i >= 0; i--) if (!m_occ[i]) slot = i;
            ev = '0;
            if (slot >= 0) ev[slot] = 1'b1;
            chk(launch_rdy == (m_busy == 0), "R1 ready", launch_rdy, m_busy == 0);
            chk(done == m_done, "R8 done pulse", done, m_done);
            chk(disp_vld == ev, "R4 slot choice", disp_vld, ev);
            if (slot >= 0) begin
                chk(disp_blk == IW'(m_nxt), "R3 block order", disp_blk, m_nxt);
                chk(disp_base == IW'(m_nxt * BD), "R6 base", disp_base, m_nxt * BD);
                chk(lane_gidx == IW'(m_nxt * BD + lane_sel), "R6 lane index",
                    lane_gidx, m_nxt * BD + lane_sel);
                for (int t = 0; t < BD; t++) et[t] = (m_nxt * BD + t) < m_n;
                for (int w = 0; w < NWP; w++) ew[w] = |et[w*WP +: WP];
                chk(disp_tmask == et, "R7 thread mask", $countones(disp_tmask), $countones(et));
                chk(disp_wmask == ew, "R7 warp mask", disp_wmask, ew);
            end
            // stimulus
            cm = '0;
            for (int i = 0; i < NS; i++) begin
                if (m_occ[i] && hold[i] == 1) cm[i] = 1'b1;
                if (!m_occ[i] && i == cyc % NS) cm[i] = 1'b1; // R5 ignored completion
            end
            slot_cmpl = cm;
            lane_sel  = LW'(cyc * 37);
            launch_vld = (li < NL);
            // R10: while busy the size input carries junk
            launch_n = (m_busy != 0) ? NW'(16'h3333) : NW'(li < NL ? sizes[li] : 0);
            // model next state
            nd = 0;
            if (m_busy == 0) begin
                if (li < NL) begin
                    m_n = sizes[li]; li++;
                    m_total = (m_n + BD - 1) / BD;
                    m_nxt = 0; m_dcnt = 0; m_disp = 0;
                    if (m_total == 0) nd = 1; // R9
                    else m_busy = 1;
                end
            end else begin
                for (int i = 0; i < NS; i++)
                    if (m_occ[i] && cm[i]) begin m_occ[i] = 0; m_dcnt++; end
                for (int i = 0; i < NS; i++)
                    if (m_occ[i] && hold[i] > 1) hold[i]--;
                if (slot >= 0) begin
                    m_occ[slot] = 1;
                    hold[slot] = 1 + ((m_nxt * 7 + slot) % 5);
                    m_nxt++; m_disp++;
                end
                if (m_dcnt == m_total) begin
                    m_busy = 0; nd = 1;
                    chk(m_disp == (m_n + BD - 1) / BD, "R2 block count", m_disp, (m_n + BD - 1) / BD);
                end
            end
            m_done = nd;
            @(negedge clk);
            cyc = cyc; // keep loop aligned on negedges
            if (!(li < NL || m_busy != 0 || m_done)) begin
                chk(done == m_done, "R9 final done", done, m_done);
            end
            // re-enter loop: next iteration checks at this negedge
            #0;
            if (li < NL || m_busy != 0 || m_done) continue;
        end
        launch_vld = 1'b0;
        @(negedge clk);
        chk(launch_rdy == 1'b1, "R1 ready at end", launch_rdy, 1);
        chk(disp_vld == '0, "R3 no dispatch at end", disp_vld, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule